// File: doc/BRIEF.md
# Serial EEPROM Host Engine (three-wire, 16-bit words)

This engine sits between on-chip logic and an external three-wire serial EEPROM that holds 16-bit words. A request arrives on a valid/ready port and names an operation, a word address, write data and an extra-word count for reads. The engine turns the request into a serial frame. It drives chip select and a divided serial clock, and it puts each data-in bit on the wire while the clock is low, so the memory samples it on the rising edge.

Reads return one response per word. The dummy zero that the memory sends before its first word is dropped. A multi-word read keeps chip select high and the clock running, and the memory's own address counter advances and wraps. After a write frame, chip select stays low for a minimum time. It is then raised again and data-out is watched until the memory reports ready, or until a timeout marks the response with an error. The enable and disable commands for writing use the all-zero opcode with two address bits as the qualifier.

Top module: `uwire_host`

## Requirements
- R1: Each frame is a 1 start bit, a 2-bit opcode (read = 10, write = 01, enable/disable = 00) and a 10-bit address, all MSB first. A write frame adds 16 data bits, MSB first. `di` changes only while `sk` is low.
- R2: `sk` stays high for exactly CLK_DIV system clocks each time it pulses. `sk` is never high while `cs` is low.
- R3: In a read, the first bit sampled after the address is discarded. The next 16 bits form the word, MSB first, on `rsp_data`.
- R4: A read with `req_len` = N returns N+1 words, each with its own `rsp_valid` pulse. `cs` stays high and no dummy bit is skipped between words. `rsp_last` is set only on the final word. Reading past word 511 continues at word 0.
- R5: Each time `cs` falls at the end of a frame, it stays low for at least CS_LOW_MIN system clocks before it rises again.
- R6: After a write, `cs` is raised again and `do_i` is polled. The response (`rsp_last` = 1, `rsp_err` = 0) follows the first high sample, once the memory is no longer busy.
- R7: If `do_i` stays low for more than POLL_TIMEOUT clocks of polling, the write ends with `rsp_err` = 1. `rsp_err` is never set without `rsp_valid` and `rsp_last`.
- R8: `req_op` encoding: 0 read, 1 write, 2 write-enable, 3 write-disable. Write-enable sends opcode 00 with address bits [9:8] = 11. Write-disable sends 00 with [9:8] = 00. Both answer with `rsp_err` = 0 and no polling. A write sent while writing is disabled leaves the stored word unchanged.
- R9: `req_ready` is high only when idle. It falls on the cycle after acceptance and stays low until the final response and the closing low time of `cs` are over.
- R10: Address bit 9 of a read or write is sent exactly as requested and always takes its slot, although the memory ignores it.
- R11: After reset, `cs`, `sk`, `di` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request taken when both high |
| req_op | input | 2 | 0 read, 1 write, 2 write-enable, 3 write-disable |
| req_addr | input | 10 | Word address, bit 9 sent as given |
| req_wdata | input | 16 | Write data |
| req_len | input | LEN_W | Extra words for a read (words = req_len + 1) |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_data | output | 16 | Read word |
| rsp_last | output | 1 | Final response of the request |
| rsp_err | output | 1 | Ready poll timed out |
| cs | output | 1 | Chip select to the memory |
| sk | output | 1 | Serial clock to the memory |
| di | output | 1 | Serial data to the memory |
| do_i | input | 1 | Serial data from the memory |

## Verification
A bit counter that is off by one moves every read word one bit. That shows up on the first `rsp_data` of a read, within about 17 serial clocks of the address. A dummy-skip flag that is not cleared cuts one bit from each word after the first, so the second word of a multi-word read is wrong as soon as it is returned. A wrong low-time or poll counter shows up at the next rise of `cs`, or in an early, late or wrong `rsp_err`, within one poll window.

// File: rtl/uwire_host.sv
module uwire_host #(
  parameter int CLK_DIV      = 4,
  parameter int CS_LOW_MIN   = 8,
  parameter int POLL_TIMEOUT = 4096,
  parameter int LEN_W        = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [9:0]       req_addr,
  input  logic [15:0]      req_wdata,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic [15:0]      rsp_data,
  output logic             rsp_last,
  output logic             rsp_err,
  output logic             cs,
  output logic             sk,
  output logic             di,
  input  logic             do_i
);
  localparam int AW    = 10;
  localparam int DW    = 16;
  localparam int FW    = 1 + 2 + AW + DW;
  localparam int NBW   = $clog2(FW + 1);
  localparam int DIVW  = $clog2(CLK_DIV + 1);
  localparam int LOWW  = $clog2(CS_LOW_MIN + 1);
  localparam int TMOW  = $clog2(POLL_TIMEOUT + 1);
  localparam logic [1:0] OP_RD = 2'd0, OP_WR = 2'd1, OP_EN = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_SEND, S_READ, S_CSLOW, S_POLL} st_t;

  st_t             st;
  logic [DIVW-1:0] div_q;
  logic [FW-1:0]   sh_q;
  logic [NBW-1:0]  nbits_q;
  logic [1:0]      op_q;
  logic [LEN_W-1:0] words_q;
  logic [3:0]      bitc_q;
  logic            dummy_q, done_q;
  logic [14:0]     word_q;
  logic [LOWW-1:0] lowc_q;
  logic [TMOW-1:0] tmo_q;

  wire tick = div_q == DIVW'(CLK_DIV - 1);

  logic [1:0]  f_opc;
  logic [9:0]  f_addr;
  always_comb begin
    f_opc  = 2'b00;
    f_addr = req_addr;
    case (req_op)
      OP_RD:   f_opc = 2'b10;
      OP_WR:   f_opc = 2'b01;
      OP_EN:   f_addr = {2'b11, 8'h00};
      default: f_addr = {2'b00, 8'h00};
    endcase
  end
  wire [FW-1:0] frame = {1'b1, f_opc, f_addr, (req_op == OP_WR) ? req_wdata : 16'h0000};

  assign req_ready = st == S_IDLE;
  assign di        = (st == S_SEND) & sh_q[FW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      div_q <= '0;
      sh_q <= '0;
      nbits_q <= '0;
      op_q <= '0;
      words_q <= '0;
      bitc_q <= '0;
      dummy_q <= 1'b0;
      done_q <= 1'b0;
      word_q <= '0;
      lowc_q <= '0;
      tmo_q <= '0;
      cs <= 1'b0;
      sk <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_data <= '0;
      rsp_last <= 1'b0;
      rsp_err <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_last  <= 1'b0;
      rsp_err   <= 1'b0;
      if (st != S_IDLE) div_q <= tick ? '0 : div_q + 1'b1;
      case (st)
        S_IDLE: if (req_valid) begin
          op_q    <= req_op;
          words_q <= req_len;
          sh_q    <= frame;
          nbits_q <= (req_op == OP_WR) ? NBW'(FW) : NBW'(FW - DW);
          cs      <= 1'b1;
          sk      <= 1'b0;
          div_q   <= '0;
          done_q  <= 1'b0;
          st      <= S_SEND;
        end
        S_SEND: if (tick) begin
          if (!sk) sk <= 1'b1;
          else begin
            sk <= 1'b0;
            if (nbits_q == NBW'(1)) begin
              if (op_q == OP_RD) begin
                bitc_q  <= '0;
                dummy_q <= 1'b1;
                st      <= S_READ;
              end else begin
                cs     <= 1'b0;
                lowc_q <= '0;
                st     <= S_CSLOW;
              end
            end else begin
              sh_q    <= {sh_q[FW-2:0], 1'b0};
              nbits_q <= nbits_q - 1'b1;
            end
          end
        end
        S_READ: if (tick) begin
          if (sk) sk <= 1'b0;
          else if (dummy_q) begin
            dummy_q <= 1'b0;
            sk      <= 1'b1;
          end else begin
            word_q <= {word_q[13:0], do_i};
            if (bitc_q == 4'd15) begin
              bitc_q    <= '0;
              rsp_valid <= 1'b1;
              rsp_data  <= {word_q, do_i};
              rsp_last  <= words_q == '0;
              if (words_q == '0) begin
                done_q <= 1'b1;
                cs     <= 1'b0;
                lowc_q <= '0;
                st     <= S_CSLOW;
              end else begin
                words_q <= words_q - 1'b1;
                sk      <= 1'b1;
              end
            end else begin
              bitc_q <= bitc_q + 1'b1;
              sk     <= 1'b1;
            end
          end
        end
        S_CSLOW: begin
          if (lowc_q == LOWW'(CS_LOW_MIN - 1)) begin
            if (!done_q && op_q == OP_WR) begin
              cs    <= 1'b1;
              tmo_q <= '0;
              st    <= S_POLL;
            end else begin
              if (!done_q) begin
                rsp_valid <= 1'b1;
                rsp_last  <= 1'b1;
              end
              st <= S_IDLE;
            end
          end else lowc_q <= lowc_q + 1'b1;
        end
        S_POLL: begin
          if ((tmo_q != '0 && do_i) || tmo_q == TMOW'(POLL_TIMEOUT)) begin
            rsp_valid <= 1'b1;
            rsp_last  <= 1'b1;
            rsp_err   <= !(tmo_q != '0 && do_i);
            cs        <= 1'b0;
            done_q    <= 1'b1;
            lowc_q    <= '0;
            st        <= S_CSLOW;
          end else tmo_q <= tmo_q + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uwire_host_chk.sv
module uwire_host_chk #(
  parameter int CS_LOW_MIN = 8
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_last,
  input logic rsp_err,
  input logic cs,
  input logic sk,
  input logic di
);
  localparam int LW = $clog2(CS_LOW_MIN + 2);
  logic [LW-1:0] low_cnt;
  logic          seen_high;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt   <= '0;
      seen_high <= 1'b0;
    end else if (cs) begin
      low_cnt   <= '0;
      seen_high <= 1'b1;
    end else if (low_cnt != LW'(CS_LOW_MIN + 1)) begin
      low_cnt <= low_cnt + 1'b1;
    end
  end

  p_di_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (sk && $past(sk)) |-> $stable(di));

  p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> !sk);

  p_cs_low_time_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs) && seen_high) |-> (low_cnt >= LW'(CS_LOW_MIN)));

  p_err_framed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_last));

  p_one_at_a_time_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind uwire_host uwire_host_chk #(.CS_LOW_MIN(CS_LOW_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_last(rsp_last), .rsp_err(rsp_err),
  .cs(cs), .sk(sk), .di(di)
);

// File: tb/sim_uwire_host.sv
`timescale 1ns/1ps
module sim_uwire_host;
  localparam int CLK_DIV = 2, CS_LOW_MIN = 5, POLL_TIMEOUT = 200, LEN_W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = '0;
  logic [9:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_ready, rsp_valid, rsp_last, rsp_err, cs, sk, di, do_i;
  logic [15:0] rsp_data;

  always #5 clk = ~clk;

  uwire_host #(.CLK_DIV(CLK_DIV), .CS_LOW_MIN(CS_LOW_MIN), .POLL_TIMEOUT(POLL_TIMEOUT), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_len(req_len),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_last(rsp_last), .rsp_err(rsp_err),
    .cs(cs), .sk(sk), .di(di), .do_i(do_i));

  int nchecks = 0, nfail = 0;
  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchecks++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // memory model
  logic [15:0] mem [0:511];
  logic m_pcs = 0, m_psk = 0, m_started = 0, m_reading = 0, m_do = 0, m_we = 0;
  int m_mode = 0, m_cnt = 0, m_busy = 0, busy_len = 40;
  logic [11:0] m_sh = 0;
  logic [15:0] m_wsh = 0, m_rsh = 0;
  logic [8:0] m_raddr = 0, m_waddr = 0;
  logic [1:0] rec_op = 0;
  logic [9:0] rec_addr = 0;
  logic [15:0] rec_wdata = 0;

  assign do_i = m_reading ? m_do : (m_busy != 0 ? 1'b0 : 1'b1);

  always @(negedge clk) begin
    if (m_busy > 0) m_busy = m_busy - 1;
    if (!cs && m_pcs) begin
      if (m_mode == 1 && m_cnt == 16) begin
        rec_wdata = m_wsh;
        if (m_we) begin
          mem[m_waddr] = m_wsh;
          m_busy = busy_len;
        end
      end
      m_mode = 0; m_started = 0; m_cnt = 0; m_reading = 0;
    end
    if (cs && sk && !m_psk) begin
      case (m_mode)
        0: if (!m_started) begin
             if (di) begin m_started = 1; m_cnt = 0; end
           end else begin
             m_sh = {m_sh[10:0], di};
             m_cnt++;
             if (m_cnt == 12) begin
               rec_op = m_sh[11:10];
               rec_addr = m_sh[9:0];
               m_cnt = 0;
               case (rec_op)
                 2'b10: begin m_mode = 2; m_reading = 1; m_do = 0;
                          m_raddr = rec_addr[8:0]; m_rsh = mem[m_raddr]; end
                 2'b01: begin m_mode = 1; m_waddr = rec_addr[8:0]; end
                 2'b00: begin
                          if (rec_addr[9:8] == 2'b11) m_we = 1;
                          else if (rec_addr[9:8] == 2'b00) m_we = 0;
                          m_mode = 3;
                        end
                 default: m_mode = 3;
               endcase
             end
           end
        1: if (m_cnt < 16) begin m_wsh = {m_wsh[14:0], di}; m_cnt++; end
        2: begin
             m_do = m_rsh[15];
             m_rsh = {m_rsh[14:0], 1'b0};
             m_cnt++;
             if (m_cnt == 16) begin
               m_cnt = 0;
               m_raddr = m_raddr + 1'b1;
               m_rsh = mem[m_raddr];
             end
           end
        default: ;
      endcase
    end
    m_pcs = cs; m_psk = sk;
  end

  // port monitors
  int di_bad = 0, skh_bad = 0, sk_nocs = 0, low_bad = 0, ready_bad = 0;
  int hcnt = 0, lcnt = 0;
  logic p_sk = 0, p_di = 0, cs_seen = 0;
  always @(negedge clk) if (rst_n) begin
    if (sk && p_sk && di !== p_di) di_bad++;
    if (sk && !cs) sk_nocs++;
    if (sk) hcnt++;
    else begin
      if (hcnt != 0 && hcnt != CLK_DIV) skh_bad++;
      hcnt = 0;
    end
    if (!cs) lcnt++;
    else begin
      if (cs_seen && lcnt > 0 && lcnt < CS_LOW_MIN) low_bad++;
      if (lcnt > 0 || !cs_seen) lcnt = 0;
      cs_seen = 1;
    end
    p_sk = sk; p_di = di;
  end

  logic [15:0] got [0:7];
  logic glast [0:7];
  int gn = 0;
  logic gerr = 0;

  task automatic issue(input logic [1:0] op, input logic [9:0] a, input logic [15:0] d,
                       input logic [LEN_W-1:0] len);
    logic fin;
    fin = 0; gn = 0; gerr = 0;
    @(negedge clk);
    req_op = op; req_addr = a; req_wdata = d; req_len = len; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    if (req_ready) ready_bad++;
    while (!fin) begin
      @(negedge clk);
      if (rsp_valid) begin
        if (gn < 8) begin got[gn] = rsp_data; glast[gn] = rsp_last; end
        gn++;
        if (rsp_last) begin fin = 1; gerr = rsp_err; end
      end else if (req_ready) ready_bad++;
    end
    while (!req_ready) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 cs after reset", cs, 0);
    chk("R11 sk after reset", sk, 0);
    chk("R11 di after reset", di, 0);
    chk("R11 rsp_valid after reset", rsp_valid, 0);
    chk("R11 req_ready after reset", req_ready, 1);
  endtask

  task automatic t_enable;
    issue(2, 10'h0AB, 16'h0, 0);
    chk("R8 enable opcode", rec_op, 2'b00);
    chk("R8 enable qualifier", rec_addr[9:8], 2'b11);
    chk("R8 enable latched", m_we, 1);
    chk("R8 enable no error", gerr, 0);
  endtask

  task automatic t_write(input logic [9:0] a, input logic [15:0] d);
    issue(1, a, d, 0);
    chk("R1 write opcode", rec_op, 2'b01);
    chk("R1 R10 write address", rec_addr, a);
    chk("R1 write data bits", rec_wdata, d);
    chk("R6 write ok", gerr, 0);
    chk("R6 response after busy ends", m_busy, 0);
    chk("R6 stored", mem[a[8:0]], d);
  endtask

  task automatic t_read_one;
    issue(0, 10'h155, 16'h0, 0);
    chk("R3 single word count", gn, 1);
    chk("R3 single word data", got[0], 16'h8001);
    chk("R4 single word last", glast[0], 1);
  endtask

  task automatic t_read_seq;
    issue(0, 10'h155, 16'h0, 1);
    chk("R4 seq count", gn, 2);
    chk("R4 seq word0", got[0], 16'h8001);
    chk("R4 seq word1 no dummy", got[1], 16'h7FFE);
    chk("R4 seq last only on final", {glast[0], glast[1]}, 2'b01);
  endtask

  task automatic t_read_wrap;
    issue(0, 10'h1FF, 16'h0, 2);
    chk("R4 wrap count", gn, 3);
    chk("R4 wrap word511", got[0], 16'hA5C3);
    chk("R4 wrap word0", got[1], 16'h3C5A);
    chk("R4 wrap word1", got[2], 16'hFFFF);
  endtask

  task automatic t_msb_dontcare;
    issue(0, 10'h355, 16'h0, 0);
    chk("R10 msb sent as given", rec_addr, 10'h355);
    chk("R10 msb ignored by memory", got[0], 16'h8001);
  endtask

  task automatic t_timeout;
    busy_len = 1000;
    issue(1, 10'h010, 16'h1357, 0);
    chk("R7 timeout error", gerr, 1);
    chk("R7 memory still busy", m_busy > 0, 1);
    while (m_busy > 0) @(negedge clk);
    busy_len = 40;
  endtask

  task automatic t_disable;
    issue(3, 10'h3FF, 16'h0, 0);
    chk("R8 disable qualifier", rec_addr[9:8], 2'b00);
    chk("R8 disable latched", m_we, 0);
    issue(1, 10'h155, 16'h1234, 0);
    chk("R8 disabled write no error", gerr, 0);
    issue(0, 10'h155, 16'h0, 0);
    chk("R8 disabled write ignored", got[0], 16'h8001);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) mem[i] = 16'h0000;
    mem[1] = 16'hFFFF;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_enable;
    t_write(10'h155, 16'h8001);
    t_write(10'h156, 16'h7FFE);
    t_write(10'h1FF, 16'hA5C3);
    t_write(10'h200, 16'h3C5A);
    t_read_one;
    t_read_seq;
    t_read_wrap;
    t_msb_dontcare;
    t_timeout;
    t_disable;
    chk("R1 di steady while sk high", di_bad, 0);
    chk("R2 sk high width", skh_bad, 0);
    chk("R2 sk only with cs", sk_nocs, 0);
    chk("R5 cs low time", low_bad, 0);
    chk("R9 ready low while busy", ready_bad, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchecks++; nfail++;
    $display("FAIL watchdog expired, R9 request never completed");
    $display("TB_RESULT checks=%0d failures=%0d", nchecks, nfail);
    $finish;
  end
endmodule